// File: doc/BRIEF.md
# Multi-Rail Power State Controller

This block is a synchronous sequencer that owns the enable levels of ten supply rails. It has three operating modes: everything off, fully on, and a deep power-saving mode in which only a subset of rails stays up. Four single-cycle request pins ask for power-up, sleep entry, sleep wake and power-down. Each request names a transition, and that transition is taken only when the present rail pattern matches the pattern it requires.

The rails fall into four groups. The always-on group holds the main always-on supply, the always-on core supply and the link high-voltage supply. The switchable group holds the link low-voltage, storage, core and PHY supplies. The high-speed pair is set by its own selector input and not by the main mode. The last rail is the supply-reset release line. Requests that are malformed, or that arrive in a pattern where they are not allowed, leave the rails untouched and raise a one-cycle error pulse. All outputs are registered and change only on an accepted transition. There are no ramp delays and no regulator feedback.

Top module: `pwr_rail_ctrl`

## Requirements
- R1: The `rails` bit layout is: bit0 main always-on, bit1 always-on core, bit2 link high-voltage, bit3 link low-voltage, bit4 storage, bit5 core, bit6 PHY, bit7 and bit8 the high-speed pair, bit9 supply-reset release. While reset is held and after it is released, all ten bits are 0, `mode` is 0 and `req_err` is 0.
- R2: Power-up is accepted only when every bit except 7 and 8 is 0. It sets all ten bits to 1.
- R3: Sleep entry is accepted only when all ten bits are 1. It clears bits 3 to 6 and holds bits 0, 1, 2 and 9.
- R4: On sleep entry, bits 7 and 8 both take the value of `hs_sel`. The two high-speed bits are always equal.
- R5: Sleep wake is accepted only when bits 0, 2 and 9 are 1 and bits 3 to 6 are 0. It sets bits 3 to 6 to 1, holds bits 0, 1, 2 and 9, and drives bits 7 and 8 to `hs_sel`.
- R6: Power-down is accepted only when every bit except 7 and 8 is 1. It clears those eight bits and leaves bits 7 and 8 unchanged.
- R7: If two or more request pins are high in the same cycle, no transition is taken, the rails and mode hold, and `req_err` is 1 in the following cycle.
- R8: A single request whose rail precondition is not met leaves the rails and mode unchanged, and `req_err` is 1 for exactly the following cycle.
- R9: In a cycle with no request, the rails and mode hold and `req_err` is 0 in the next cycle.
- R10: `mode` reads 0 when off, 1 when on and 2 when in sleep. It changes only on accepted transitions: 1 after power-up or wake, 2 after sleep entry and 0 after power-down. It never reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_up | input | 1 | Power-up request pulse |
| req_sleep | input | 1 | Sleep-entry request pulse |
| req_wake | input | 1 | Sleep-wake request pulse |
| req_down | input | 1 | Power-down request pulse |
| hs_sel | input | 1 | Level for the high-speed pair on sleep entry or wake |
| rails | output | 10 | Registered rail enables, layout as in R1 |
| mode | output | 2 | Current mode: 0 off, 1 on, 2 sleep |
| req_err | output | 1 | One-cycle pulse flagging a rejected request |

## Verification
A request is sampled at a rising edge. The new rail pattern, the new mode and the error pulse all appear at that same edge, so every result is due exactly one cycle after its request. The driver applies each request at a falling edge and pushes the expected outcome into the scoreboard just after the capturing rising edge. The monitor compares at the next falling edge, so every comparison happens half a cycle after the register update. Idle steps queued after rejected requests confirm that the error pulse lasts only one cycle.

// File: rtl/pwr_rail_pkg.sv
package pwr_rail_pkg;
  localparam int RAIL_W  = 10;
  localparam int NUM_REQ = 4;

  localparam int B_AO_MAIN = 0;
  localparam int B_AO_CORE = 1;
  localparam int B_LINK_HV = 2;
  localparam int B_LINK_LV = 3;
  localparam int B_STORE   = 4;
  localparam int B_CORE    = 5;
  localparam int B_PHY     = 6;
  localparam int B_HS_A    = 7;
  localparam int B_HS_B    = 8;
  localparam int B_SUP_REL = 9;

  localparam int Q_UP    = 0;
  localparam int Q_SLEEP = 1;
  localparam int Q_WAKE  = 2;
  localparam int Q_DOWN  = 3;

  localparam logic [RAIL_W-1:0] M_ALL    = {RAIL_W{1'b1}};
  localparam logic [RAIL_W-1:0] M_HS     = (RAIL_W'(1) << B_HS_A) | (RAIL_W'(1) << B_HS_B);
  localparam logic [RAIL_W-1:0] M_NONHS  = M_ALL & ~M_HS;
  localparam logic [RAIL_W-1:0] M_SWITCH = (RAIL_W'(1) << B_LINK_LV) | (RAIL_W'(1) << B_STORE)
                                         | (RAIL_W'(1) << B_CORE)    | (RAIL_W'(1) << B_PHY);
  localparam logic [RAIL_W-1:0] M_WAKE_ON = (RAIL_W'(1) << B_AO_MAIN) | (RAIL_W'(1) << B_LINK_HV)
                                          | (RAIL_W'(1) << B_SUP_REL);

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_ON    = 2'd1,
    MODE_SLEEP = 2'd2
  } mode_e;

  function automatic logic pre_ok(input int idx, input logic [RAIL_W-1:0] r);
    logic ok;
    case (idx)
      Q_UP:    ok = (r & M_NONHS) == '0;
      Q_SLEEP: ok = (r == M_ALL);
      Q_WAKE:  ok = ((r & M_WAKE_ON) == M_WAKE_ON) && ((r & M_SWITCH) == '0);
      Q_DOWN:  ok = (r & M_NONHS) == M_NONHS;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/pwr_req_guard.sv
module pwr_req_guard
  import pwr_rail_pkg::*;
(
  input  logic [NUM_REQ-1:0] req,
  input  logic [RAIL_W-1:0]  rails_q,
  output logic [NUM_REQ-1:0] go,
  output logic               illegal
);
  logic [NUM_REQ-1:0] ok;
  logic               single;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_pre
    assign ok[i] = pre_ok(i, rails_q);
  end

  assign single  = $onehot(req);
  assign go      = single ? (req & ok) : '0;
  assign illegal = (|req) && (go == '0);
endmodule

// File: rtl/pwr_rail_next.sv
module pwr_rail_next
  import pwr_rail_pkg::*;
(
  input  logic [NUM_REQ-1:0] go,
  input  logic [RAIL_W-1:0]  rails_q,
  input  mode_e              mode_q,
  input  logic               hs_sel,
  output logic [RAIL_W-1:0]  rails_d,
  output mode_e              mode_d
);
  logic [RAIL_W-1:0] hs_val;
  assign hs_val = {RAIL_W{hs_sel}} & M_HS;

  always_comb begin
    rails_d = rails_q;
    mode_d  = mode_q;
    unique case (1'b1)
      go[Q_UP]: begin
        rails_d = M_ALL;
        mode_d  = MODE_ON;
      end
      go[Q_SLEEP]: begin
        rails_d = (rails_q & ~(M_SWITCH | M_HS)) | hs_val;
        mode_d  = MODE_SLEEP;
      end
      go[Q_WAKE]: begin
        rails_d = (rails_q & ~M_HS) | M_SWITCH | hs_val;
        mode_d  = MODE_ON;
      end
      go[Q_DOWN]: begin
        rails_d = rails_q & M_HS;
        mode_d  = MODE_OFF;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_rail_ctrl.sv
module pwr_rail_ctrl
  import pwr_rail_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_up,
  input  logic              req_sleep,
  input  logic              req_wake,
  input  logic              req_down,
  input  logic              hs_sel,
  output logic [RAIL_W-1:0] rails,
  output logic [1:0]        mode,
  output logic              req_err
);
  logic [NUM_REQ-1:0] req, go;
  logic               illegal;
  logic [RAIL_W-1:0]  rails_q, rails_d;
  mode_e              mode_q, mode_d;
  logic               err_q;

  always_comb begin
    req          = '0;
    req[Q_UP]    = req_up;
    req[Q_SLEEP] = req_sleep;
    req[Q_WAKE]  = req_wake;
    req[Q_DOWN]  = req_down;
  end

  pwr_req_guard u_guard (
    .req     (req),
    .rails_q (rails_q),
    .go      (go),
    .illegal (illegal)
  );

  pwr_rail_next u_next (
    .go      (go),
    .rails_q (rails_q),
    .mode_q  (mode_q),
    .hs_sel  (hs_sel),
    .rails_d (rails_d),
    .mode_d  (mode_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rails_q <= '0;
      mode_q  <= MODE_OFF;
      err_q   <= 1'b0;
    end else begin
      rails_q <= rails_d;
      mode_q  <= mode_d;
      err_q   <= illegal;
    end
  end

  assign rails   = rails_q;
  assign mode    = mode_q;
  assign req_err = err_q;

  // R2: power-up from a fully-off pattern lights every rail
  a_r2_up_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (req == (NUM_REQ'(1) << Q_UP) && (rails_q & M_NONHS) == '0)
      |=> (rails == M_ALL && mode == MODE_ON));
  // R4: the high-speed pair always moves together
  a_r4_hs_pair_match: assert property (@(posedge clk) disable iff (!rst_n)
    rails[B_HS_A] == rails[B_HS_B]);
  // R6: power-down leaves the high-speed pair alone
  a_r6_down_keeps_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (req == (NUM_REQ'(1) << Q_DOWN) && mode_q == MODE_ON)
      |=> ($stable(rails & M_HS) && (rails & M_NONHS) == '0 && mode == MODE_OFF));
  // R7: several simultaneous requests are rejected
  a_r7_multi_reject: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req) > 1) |=> (req_err && $stable(rails) && $stable(mode)));
  // R8: an error cycle never coincides with a rail change
  a_r8_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ($stable(rails) && $stable(mode)));
  // R9: idle cycles change nothing
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> ($stable(rails) && !req_err));
  // R10: mode code 3 is never produced
  a_r10_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
  // R3: sleep mode keeps the always-on group and reset release up, switched rails down
  a_r3_sleep_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP) |-> ((rails & M_SWITCH) == '0 && (rails & M_WAKE_ON) == M_WAKE_ON));
endmodule

// File: tb/tb_pwr_rail_ctrl.sv
module tb_pwr_rail_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_up = 1'b0, req_sleep = 1'b0, req_wake = 1'b0, req_down = 1'b0;
  logic       hs_sel = 1'b0;
  logic [9:0] rails;
  logic [1:0] mode;
  logic       req_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [9:0] r;
    logic [1:0] m;
    logic       e;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [9:0] m_rails = '0;
  logic [1:0] m_mode  = 2'd0;

  localparam logic [9:0] HS  = 10'b01_1000_0000;
  localparam logic [9:0] NHS = 10'b10_0111_1111;
  localparam logic [9:0] SW  = 10'b00_0111_1000;
  localparam logic [9:0] WON = 10'b10_0000_0101;

  always #5 clk = ~clk;

  pwr_rail_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_sleep(req_sleep),
    .req_wake(req_wake), .req_down(req_down), .hs_sel(hs_sel),
    .rails(rails), .mode(mode), .req_err(req_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // rq bits: [0] up, [1] sleep, [2] wake, [3] down
  task automatic step(input logic [3:0] rq, input logic hs, input string tag);
    exp_t x;
    logic [9:0] hv;
    @(negedge clk);
    {req_down, req_wake, req_sleep, req_up} = rq;
    hs_sel = hs;
    hv = hs ? HS : '0;
    x.e = 1'b0;
    if (rq == 4'b0) begin
      x.e = 1'b0;
    end else if ($countones(rq) > 1) begin
      x.e = 1'b1;
    end else if (rq[0]) begin
      if ((m_rails & NHS) == '0) begin m_rails = '1; m_mode = 2'd1; end
      else x.e = 1'b1;
    end else if (rq[1]) begin
      if (m_rails == '1) begin m_rails = (m_rails & ~(SW | HS)) | hv; m_mode = 2'd2; end
      else x.e = 1'b1;
    end else if (rq[2]) begin
      if ((m_rails & WON) == WON && (m_rails & SW) == '0) begin
        m_rails = (m_rails & ~HS) | SW | hv; m_mode = 2'd1;
      end else x.e = 1'b1;
    end else begin
      if ((m_rails & NHS) == NHS) begin m_rails = m_rails & HS; m_mode = 2'd0; end
      else x.e = 1'b1;
    end
    x.r = m_rails;
    x.m = m_mode;
    x.tag = tag;
    @(posedge clk);
    #1;
    q.push_back(x);
    {req_down, req_wake, req_sleep, req_up} = 4'b0;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk(rails === x.r, x.tag, "rails", 32'(rails), 32'(x.r));
      chk(mode === x.m, x.tag, "mode", 32'(mode), 32'(x.m));
      chk(req_err === x.e, x.tag, "req_err", 32'(req_err), 32'(x.e));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs while reset is held
    chk(rails === '0 && mode === 2'd0 && req_err === 1'b0, "R1", "in reset",
        {20'd0, rails, mode}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs after release
    chk(rails === '0, "R1", "rails after reset", 32'(rails), 32'd0);
    chk(mode === 2'd0, "R1", "mode after reset", 32'(mode), 32'd0);
    chk(req_err === 1'b0, "R1", "err after reset", 32'(req_err), 32'd0);

    step(4'b0000, 0, "R9 idle off");
    step(4'b0100, 0, "R8 wake from off");
    step(4'b0000, 0, "R8 err one cycle");
    step(4'b0010, 0, "R8 sleep from off");
    step(4'b1000, 0, "R6 down from off rejected");
    step(4'b0001, 0, "R2 power up");
    step(4'b0001, 0, "R8 up when on");
    step(4'b1001, 0, "R7 up+down together");
    step(4'b0000, 0, "R9 idle on");
    step(4'b0010, 0, "R3 R4 sleep hs=0");
    step(4'b0000, 0, "R10 idle sleep");
    step(4'b0010, 1, "R8 sleep when asleep");
    step(4'b1000, 0, "R6 down from sleep rejected");
    step(4'b0001, 0, "R2 up from sleep rejected");
    step(4'b0100, 1, "R5 wake hs=1");
    step(4'b0010, 1, "R4 sleep hs=1");
    step(4'b0100, 0, "R5 wake hs=0");
    step(4'b0010, 1, "R3 sleep rejected with hs low");
    step(4'b1000, 0, "R6 down hs low");
    step(4'b0001, 0, "R2 up from off");
    step(4'b0010, 1, "R4 sleep hs=1 again");
    step(4'b0100, 1, "R5 wake keeps hs=1");
    step(4'b1000, 0, "R6 down holds hs high");
    step(4'b0110, 1, "R7 sleep+wake together");
    step(4'b0001, 0, "R2 up with hs already high");
    step(4'b1110, 0, "R7 three requests");
    step(4'b1000, 1, "R10 down to off");
    step(4'b0000, 0, "R9 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule